// File: doc/BRIEF.md
# Supervisor Counter Inhibit Alias

This block keeps the per-counter inhibit register of a hart's performance counter bank. It also exposes a second, filtered view of that register to the supervisor. Machine-mode software reaches the full register at its own CSR address. Supervisor software reaches a masked alias at address 0x120. Through the alias, only the counters that the machine has handed down are visible and writable. Every inhibit bit drives the counter bank directly, and a counter whose bit is set stops counting.

Each access is presented for one cycle. The block answers in the same cycle with read data and with an illegal-instruction or virtual-instruction indication. An accepted write takes effect at the next rising clock edge.

The handed-down set comes from a counter-enable mask. A single enable bit gates the alias as a whole. The current privilege level and a virtualization flag decide which exception, if any, an access raises.

Top module: `cntinh_alias`

## Requirements
- R1: After reset every inhibit output is 0, and a machine-mode read of the machine address returns 0.
- R2: `inhibit_o` always equals the stored register, and a machine-mode read of the machine address (0x320 by default) returns that same value.
- R3: A machine-mode write to the machine address loads every implemented bit from `acc_wdata`, whatever the delegation mask holds. Bit 1 and the bits at or above `NUM_CNT` always read and drive 0.
- R4: An accepted read of the supervisor address 0x120 returns the stored register ANDed with `deleg_mask`.
- R5: An accepted write to the supervisor address changes only the bits whose `deleg_mask` bit is 1. All other stored bits keep their values.
- R6: While `deleg_en` is 0, any access to the supervisor address raises `acc_illegal`, whatever the privilege or virtualization. The stored register is left unchanged.
- R7: While `deleg_en` is 1, a supervisor-address access with `virt_mode`=1 and a privilege other than machine raises `acc_virtual` and leaves the register unchanged.
- R8: While `deleg_en` is 1, a supervisor-address access from non-virtualized user level (`priv_mode` 2'b00, or the reserved value 2'b10) raises `acc_illegal` and leaves the register unchanged.
- R9: Any access to the machine address from a privilege other than machine (`priv_mode` != 2'b11) raises `acc_illegal` and does not write.
- R10: An access to any other address raises no exception, returns 0 and writes nothing.
- R11: `acc_illegal` and `acc_virtual` are never both 1, and `acc_rdata` is 0 whenever either is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | CSR access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | CSR address of the access |
| acc_wdata | input | DATA_W | Write data |
| priv_mode | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine, 10 reserved (treated as user) |
| virt_mode | input | 1 | 1 when running as a virtualized guest |
| deleg_en | input | 1 | Enables the supervisor alias as a whole |
| deleg_mask | input | DATA_W | Per-counter delegation (counter-enable) mask |
| acc_rdata | output | DATA_W | Read data, valid in the access cycle |
| acc_illegal | output | 1 | Illegal-instruction exception for this access |
| acc_virtual | output | 1 | Virtual-instruction exception for this access |
| inhibit_o | output | DATA_W | Per-counter inhibit outputs to the counter bank |

## Verification
The bench sweeps every combination of privilege, virtualization, enable, target address and direction. Before each access it seeds the register with a fresh pattern and uses a fresh mask. One corner case is a supervisor write that leaks into undelegated counters, which would show up as a changed inhibit bit outside the mask. Another is a faulting access that still writes, which would move the register after an exception. The bench also watches the priority between the disabled-alias illegal case and the guest virtual case. A design that checked virtualization first would report the wrong exception kind when the alias is off. Seeds and write data set bit 1, so a design that failed to tie the timer position to zero would show it in both views.

// File: rtl/cntinh_pkg.sv
package cntinh_pkg;

   typedef enum logic [1:0] {
      PRIV_U   = 2'b00,
      PRIV_S   = 2'b01,
      PRIV_RSV = 2'b10,
      PRIV_M   = 2'b11
   } priv_e;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_MACH = 2'd1,
      TGT_SUP  = 2'd2
   } tgt_e;

   typedef struct packed {
      tgt_e tgt;
      logic ok;
      logic illegal;
      logic virt_exc;
   } acc_dec_t;

endpackage

// File: rtl/cntinh_decode.sv
module cntinh_decode
   import cntinh_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] SUP_ADDR  = 12'h120,
   parameter logic [ADDR_W-1:0] MACH_ADDR = 12'h320
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   input  priv_e             priv,
   input  logic              virt,
   input  logic              deleg_en,
   output acc_dec_t          dec
);

   logic is_m, is_s, in_guest;

   assign is_m     = (priv == PRIV_M);
   assign is_s     = (priv == PRIV_S);
   assign in_guest = virt && !is_m;

   always_comb begin
      dec = '{tgt: TGT_NONE, ok: 1'b0, illegal: 1'b0, virt_exc: 1'b0};
      if (valid) begin
         if (addr == MACH_ADDR) begin
            dec.tgt     = TGT_MACH;
            dec.illegal = !is_m;
         end else if (addr == SUP_ADDR) begin
            dec.tgt = TGT_SUP;
            // disabled alias outranks the guest check
            if (!deleg_en)
               dec.illegal = 1'b1;
            else if (in_guest)
               dec.virt_exc = 1'b1;
            else if (!(is_m || is_s))
               dec.illegal = 1'b1;
         end
         dec.ok = (dec.tgt != TGT_NONE) && !dec.illegal && !dec.virt_exc;
      end
   end

endmodule

// File: rtl/cntinh_store.sv
module cntinh_store #(
   parameter int unsigned DATA_W = 32,
   parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_mach,
   input  logic              wr_sup,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] state
);

   logic unused_bits;
   assign unused_bits = ^{wdata & ~IMPL_MASK, mask & ~IMPL_MASK};

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (IMPL_MASK[i]) begin : g_impl
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= 1'b0;
            else if (wr_mach || (wr_sup && mask[i]))
               q <= wdata[i];
         end
         assign state[i] = q;
      end else begin : g_tied
         assign state[i] = 1'b0;
      end
   end

endmodule

// File: rtl/cntinh_rdmux.sv
module cntinh_rdmux
   import cntinh_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  acc_dec_t          dec,
   input  logic [DATA_W-1:0] state,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] rdata
);

   always_comb begin
      rdata = '0;
      if (dec.ok) begin
         unique case (dec.tgt)
            TGT_MACH: rdata = state;
            TGT_SUP:  rdata = state & mask;
            default:  rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/cntinh_alias.sv
module cntinh_alias
   import cntinh_pkg::*;
#(
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned NUM_CNT        = 32,
   parameter int unsigned ADDR_W         = 12,
   parameter int unsigned TIMER_BIT      = 1,
   parameter bit          HARDWIRE_TIMER = 1'b1,
   parameter logic [ADDR_W-1:0] SUP_ADDR  = 12'h120,
   parameter logic [ADDR_W-1:0] MACH_ADDR = 12'h320
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic [1:0]        priv_mode,
   input  logic              virt_mode,
   input  logic              deleg_en,
   input  logic [DATA_W-1:0] deleg_mask,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              acc_illegal,
   output logic              acc_virtual,
   output logic [DATA_W-1:0] inhibit_o
);

   localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
   localparam logic [DATA_W-1:0] CNT_FIELD =
      (NUM_CNT >= DATA_W) ? '1 : ((ONE << NUM_CNT) - ONE);
   localparam logic [DATA_W-1:0] IMPL_MASK =
      HARDWIRE_TIMER ? (CNT_FIELD & ~(ONE << TIMER_BIT)) : CNT_FIELD;

   if (NUM_CNT < 3 || NUM_CNT > DATA_W) begin : g_chk_cnt
      $error("cntinh_alias: NUM_CNT must lie in 3..DATA_W");
   end
   if (TIMER_BIT >= NUM_CNT) begin : g_chk_tmr
      $error("cntinh_alias: TIMER_BIT out of range");
   end
   if (SUP_ADDR == MACH_ADDR) begin : g_chk_addr
      $error("cntinh_alias: the two CSR addresses must differ");
   end

   acc_dec_t          dec;
   logic              wr_mach, wr_sup;
   logic [DATA_W-1:0] state;

   cntinh_decode #(
      .ADDR_W   (ADDR_W),
      .SUP_ADDR (SUP_ADDR),
      .MACH_ADDR(MACH_ADDR)
   ) u_decode (
      .valid   (acc_valid),
      .addr    (acc_addr),
      .priv    (priv_e'(priv_mode)),
      .virt    (virt_mode),
      .deleg_en(deleg_en),
      .dec     (dec)
   );

   assign wr_mach = acc_write && dec.ok && (dec.tgt == TGT_MACH);
   assign wr_sup  = acc_write && dec.ok && (dec.tgt == TGT_SUP);

   cntinh_store #(
      .DATA_W   (DATA_W),
      .IMPL_MASK(IMPL_MASK)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_mach(wr_mach),
      .wr_sup (wr_sup),
      .wdata  (acc_wdata),
      .mask   (deleg_mask),
      .state  (state)
   );

   cntinh_rdmux #(
      .DATA_W(DATA_W)
   ) u_rdmux (
      .dec  (dec),
      .state(state),
      .mask (deleg_mask),
      .rdata(acc_rdata)
   );

   assign acc_illegal = dec.illegal;
   assign acc_virtual = dec.virt_exc;
   assign inhibit_o   = state;

endmodule

// File: rtl/cntinh_chk.sv
module cntinh_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 12,
   parameter logic [ADDR_W-1:0] SUP_ADDR  = 12'h120,
   parameter logic [ADDR_W-1:0] MACH_ADDR = 12'h320,
   parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [DATA_W-1:0] acc_wdata,
   input logic [1:0]        priv_mode,
   input logic              virt_mode,
   input logic              deleg_en,
   input logic [DATA_W-1:0] deleg_mask,
   input logic [DATA_W-1:0] acc_rdata,
   input logic              acc_illegal,
   input logic              acc_virtual,
   input logic [DATA_W-1:0] inhibit_o
);

   logic sup_hit, mach_hit, faulted;
   assign sup_hit  = acc_valid && (acc_addr == SUP_ADDR);
   assign mach_hit = acc_valid && (acc_addr == MACH_ADDR);
   assign faulted  = acc_illegal || acc_virtual;

   a_r3_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (inhibit_o & ~IMPL_MASK) == '0);

   a_r3_mach_write: assert property (@(posedge clk) disable iff (!rst_n)
      (mach_hit && acc_write && priv_mode == 2'b11) |=>
      (inhibit_o == ($past(acc_wdata) & IMPL_MASK)));

   a_r4_sup_read: assert property (@(posedge clk) disable iff (!rst_n)
      (sup_hit && !acc_write && !faulted) |-> (acc_rdata == (inhibit_o & deleg_mask)));

   a_r5_sup_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (sup_hit && acc_write && !faulted) |=>
      ((inhibit_o & ~$past(deleg_mask)) == ($past(inhibit_o) & ~$past(deleg_mask))));

   a_r6_disabled_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      (sup_hit && !deleg_en) |-> (acc_illegal && !acc_virtual));

   a_r6_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && faulted) |=> (inhibit_o == $past(inhibit_o)));

   a_r7_guest_virtual: assert property (@(posedge clk) disable iff (!rst_n)
      (sup_hit && deleg_en && virt_mode && priv_mode != 2'b11) |-> acc_virtual);

   a_r8_user_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      (sup_hit && deleg_en && !virt_mode && !priv_mode[0]) |-> acc_illegal);

   a_r9_mach_from_lower: assert property (@(posedge clk) disable iff (!rst_n)
      (mach_hit && priv_mode != 2'b11) |-> acc_illegal);

   a_r10_other_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !sup_hit && !mach_hit) |-> (!faulted && acc_rdata == '0));

   a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_illegal && acc_virtual));

   a_r11_fault_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      faulted |-> (acc_rdata == '0));

endmodule

bind cntinh_alias cntinh_chk #(
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .SUP_ADDR (SUP_ADDR),
   .MACH_ADDR(MACH_ADDR),
   .IMPL_MASK(IMPL_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_write (acc_write),
   .acc_addr  (acc_addr),
   .acc_wdata (acc_wdata),
   .priv_mode (priv_mode),
   .virt_mode (virt_mode),
   .deleg_en  (deleg_en),
   .deleg_mask(deleg_mask),
   .acc_rdata (acc_rdata),
   .acc_illegal(acc_illegal),
   .acc_virtual(acc_virtual),
   .inhibit_o (inhibit_o)
);

// File: tb/tb_cntinh_alias.sv
`timescale 1ns/1ps
module tb_cntinh_alias;

   localparam int unsigned DW = 32;
   localparam int unsigned NC = 8;
   localparam logic [11:0] SADDR = 12'h120;
   localparam logic [11:0] MADDR = 12'h320;
   localparam logic [11:0] OADDR = 12'h7C0;
   localparam logic [31:0] IMPL  = 32'h0000_00FD;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [11:0] acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic [1:0]  priv_mode = 2'b11;
   logic        virt_mode = 1'b0, deleg_en = 1'b0;
   logic [31:0] deleg_mask = '0;
   logic [31:0] acc_rdata, inhibit_o;
   logic        acc_illegal, acc_virtual;

   int n_checks = 0;
   int n_fail   = 0;
   logic [31:0] model = '0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cntinh_alias #(.DATA_W(DW), .NUM_CNT(NC)) dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .priv_mode(priv_mode),
      .virt_mode(virt_mode), .deleg_en(deleg_en), .deleg_mask(deleg_mask),
      .acc_rdata(acc_rdata), .acc_illegal(acc_illegal), .acc_virtual(acc_virtual),
      .inhibit_o(inhibit_o)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic access(input logic [11:0] a, input logic w, input logic [31:0] d,
                         input logic [1:0] p, input logic v, input logic en,
                         input logic [31:0] m, output logic [31:0] rd,
                         output logic il, output logic vi);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d;
      priv_mode = p; virt_mode = v; deleg_en = en; deleg_mask = m;
      #2;
      rd = acc_rdata; il = acc_illegal; vi = acc_virtual;
      @(posedge clk);
      #1 acc_valid = 1'b0; acc_write = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] rd;
      logic il, vi;
      int idx = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #2 check(inhibit_o == 32'h0, "R1", inhibit_o, 32'h0);
      access(MADDR, 1'b0, '0, 2'b11, 1'b0, 1'b0, '0, rd, il, vi);
      check(rd == 32'h0 && !il, "R1", rd, 32'h0);

      // all ones through machine view: bit 1 and upper bits stay clear
      access(MADDR, 1'b1, 32'hFFFF_FFFF, 2'b11, 1'b0, 1'b0, '0, rd, il, vi);
      model = IMPL;
      check(inhibit_o == IMPL, "R3", inhibit_o, IMPL);

      for (int p = 0; p < 4; p++)
      for (int v = 0; v < 2; v++)
      for (int e = 0; e < 2; e++)
      for (int a = 0; a < 3; a++)
      for (int w = 0; w < 2; w++) begin
         logic [31:0] seed, mask, wd, exp_rd, act_m;
         logic [11:0] addr;
         logic e_il, e_vi, is_m, guest;
         string req;
         idx++;
         seed = 32'hA5A5_5A5A ^ (idx * 32'h1357_9BDF);
         mask = 32'h3C3C_C3C3 ^ (idx * 32'h0F1E_2D3B);
         wd   = ~seed ^ {idx[7:0], idx[7:0], idx[7:0], idx[7:0]};
         addr = (a == 0) ? SADDR : (a == 1) ? MADDR : OADDR;

         // seed register with a masked-irrelevant machine write (R3)
         access(MADDR, 1'b1, seed, 2'b11, 1'b0, e[0], ~mask, rd, il, vi);
         model = seed & IMPL;
         check(inhibit_o == model, "R3", inhibit_o, model);
         access(MADDR, 1'b0, '0, 2'b11, 1'b1, e[0], mask, rd, il, vi);
         check(rd == model && !il && !vi, "R2", rd, model);

         // expected outcome of the swept access
         is_m  = (p == 3);
         guest = v[0] && !is_m;
         e_il = 1'b0; e_vi = 1'b0;
         if (a == 1) begin
            e_il = !is_m; req = is_m ? (w ? "R3" : "R2") : "R9";
         end else if (a == 0) begin
            if (!e[0])               begin e_il = 1'b1; req = "R6"; end
            else if (guest)          begin e_vi = 1'b1; req = "R7"; end
            else if (!(is_m || p == 1)) begin e_il = 1'b1; req = "R8"; end
            else req = w ? "R5" : "R4";
         end else req = "R10";

         exp_rd = '0;
         if (!e_il && !e_vi) begin
            if (a == 1) exp_rd = model;
            else if (a == 0) exp_rd = model & mask;
         end

         access(addr, w[0], wd, p[1:0], v[0], e[0], mask, rd, il, vi);
         check(il == e_il, req, {31'b0, il}, {31'b0, e_il});
         check(vi == e_vi, req, {31'b0, vi}, {31'b0, e_vi});
         check(!(il && vi), "R11", {30'b0, il, vi}, 32'h0);
         if (!w[0]) check(rd == exp_rd, req, rd, exp_rd);
         else if (il || vi) check(rd == 32'h0, "R11", rd, 32'h0);

         if (w[0] && !e_il && !e_vi) begin
            if (a == 1) model = wd & IMPL;
            else if (a == 0) model = (model & ~(mask & IMPL)) | (wd & mask & IMPL);
         end
         act_m = inhibit_o;
         check(act_m == model, req, act_m, model);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule